// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog counter that protects a system against software that has stopped running. Software must keep writing a fixed key byte to the clear register before the counter reaches its terminal count. If it fails to, the block raises a one-cycle internal reset request. The overflow period and a stop option sit in a mode register. After reset, that register takes exactly one valid byte write.

Register accesses must follow strict rules, and any illegal access also raises the reset request:

- a wrong key;
- any single-bit write to either register;
- a second write to the mode register;
- a mode byte whose fixed upper bits are wrong.

When software has chosen to stop the watchdog, those access rules are relaxed. A configuration strap decides what happens in the low-power states. Either the count runs straight through HALT and STOP, or it pauses during them and holds its value until they end.

Top module: `wdt_keyguard`

## Requirements
- R1: After reset, `rst_req` is 0 and the counter is zero. The mode register reads 0x67: running, period select 7, bit 4 clear, and bits 7:5 = 011.
- R2: While running, `rst_req` pulses for one cycle once 2^(BASE_LOG+P) counting cycles have passed since the last clear, where P is mode bits 2:0. The count then restarts from zero.
- R3: A byte write of 0xAC to the key address clears the counter and raises no request. If it coincides with the terminal count, the clear wins.
- R4: A read of the key address returns 0x9A. A read of the mode address returns the stored mode byte. Any other read address returns 0.
- R5: A byte write of any value other than 0xAC to the key address raises `rst_req` in the following cycle.
- R6: A single-bit write (`bus_bitop`=1) to the key address raises `rst_req`, whatever its data.
- R7: The first byte write to the mode address whose bits 7:5 are 011 is stored and clears the counter. Its bits 2:0 select the period, and bit 4 set to 1 stops the watchdog. Bit 3 has no effect.
- R8: A mode write whose bits 7:5 differ from 011 raises `rst_req` and is not stored.
- R9: A mode write after the first accepted one, or a single-bit mode write, raises `rst_req` and leaves the mode register unchanged.
- R10: Once the watchdog is stopped by mode bit 4, the counter no longer advances and never overflows. A second mode write, a wrong key and a single-bit key write then raise no request, and the mode register stays unchanged.
- R11: With `clk_may_stop`=1, `halt_i` or `stop_i` pauses the count. The count value is held and resumes from where it left off with the same period.
- R12: With `clk_may_stop`=0, the count continues through `halt_i` and `stop_i` and overflows as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| bus_bitop | input | 1 | Marks the write as a single-bit access |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (combinational) |
| halt_i | input | 1 | Core is in HALT |
| stop_i | input | 1 | Core is in STOP |
| clk_may_stop | input | 1 | Strap: 1 lets low-power states pause the count |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
Periods are tested two ways: by letting the default longest period expire, and by letting a short period selected by the mode write expire several times in a row. This separates errors in period selection from errors in restarting the count.

Access stimulus falls into four groups, all sent while running and sent again while stopped, so the stop exception is isolated from the access checks themselves:
- correct keys and wrong keys;
- single-bit writes;
- second mode writes;
- mode bytes with bad fixed bits.

HALT/STOP windows are applied under both strap values. Overflow timing then shows whether the count was held, cleared or kept running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] CLEAR_KEY  = 8'hAC;
    localparam logic [7:0] KEY_RDVAL  = 8'h9A;
    localparam logic [2:0] MODE_FIXED = 3'b011;
    localparam logic [7:0] MODE_INIT  = 8'h67;

    typedef struct packed {
        logic [2:0] fixed;
        logic       off;
        logic       spare;
        logic [2:0] per;
    } mode_t;

    typedef struct packed {
        logic clr;
        logic viol;
    } wr_evt_t;

    function automatic logic fixed_ok(input logic [7:0] b);
        return b[7:5] == MODE_FIXED;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int MODE_ADDR = 0,
    parameter int KEY_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_bitop,
    output mode_t             mode_q,
    output logic              locked_q,
    output logic              wd_off,
    output wr_evt_t           evt
);

    logic hit_mode, hit_key, mode_take, key_ok;

    always_comb begin
        wd_off    = locked_q && mode_q.off;
        hit_mode  = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));
        hit_key   = bus_wr && (bus_addr == ADDR_W'(KEY_ADDR));
        mode_take = hit_mode && !bus_bitop && !locked_q && fixed_ok(bus_wdata);
        key_ok    = hit_key && !bus_bitop && (bus_wdata == CLEAR_KEY);
        evt.clr   = key_ok || mode_take;
        evt.viol  = ((hit_mode && !mode_take) || (hit_key && !key_ok)) && !wd_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= mode_t'(MODE_INIT);
            locked_q <= 1'b0;
        end else if (mode_take) begin
            mode_q   <= mode_t'(bus_wdata);
            locked_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int BASE_LOG = 4,
    parameter int CNT_W    = BASE_LOG + 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [2:0]       per_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    logic [CNT_W-1:0] term;

    always_comb begin
        term = {CNT_W{1'b1}} >> (3'd7 - per_sel);
        ovf  = run && !clr && (cnt_q == term);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || ovf)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int MODE_ADDR = 0,
    parameter int KEY_ADDR  = 1,
    parameter int BASE_LOG  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_bitop,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              halt_i,
    input  logic              stop_i,
    input  logic              clk_may_stop,
    output logic              rst_req
);

    localparam int CNT_W = BASE_LOG + 7;

    mode_t            mode_q;
    logic             locked_q;
    logic             wd_off;
    wr_evt_t          evt;
    logic             run;
    logic             ovf;
    logic [CNT_W-1:0] cnt_q;

    wdt_regs #(
        .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_bitop(bus_bitop),
        .mode_q(mode_q), .locked_q(locked_q), .wd_off(wd_off), .evt(evt)
    );

    assign run = !wd_off && !(clk_may_stop && (halt_i || stop_i));

    wdt_count #(.BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .clr(evt.clr),
        .per_sel(mode_q.per), .cnt_q(cnt_q), .ovf(ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= evt.viol || ovf;
    end

    always_comb begin
        if (rd_addr == ADDR_W'(MODE_ADDR))     rd_data = mode_q;
        else if (rd_addr == ADDR_W'(KEY_ADDR)) rd_data = KEY_RDVAL;
        else                                   rd_data = 8'h00;
    end

endmodule

// File: rtl/wdt_keyguard_chk.sv
module wdt_keyguard_chk #(
    parameter int ADDR_W   = 2,
    parameter int MODE_ADDR = 0,
    parameter int KEY_ADDR = 1,
    parameter int CNT_W    = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_bitop,
    input logic              halt_i,
    input logic              stop_i,
    input logic              clk_may_stop,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [7:0]        mode_q,
    input logic              locked_q,
    input logic              wd_off
);

    logic key_wr, mode_wr;
    assign key_wr  = bus_wr && (bus_addr == ADDR_W'(KEY_ADDR));
    assign mode_wr = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));

    p_key_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (key_wr && !bus_bitop && bus_wdata == 8'hAC) |=> (cnt_q == '0 && !rst_req));

    p_bad_key_r5: assert property (@(posedge clk) disable iff (rst)
        (key_wr && !bus_bitop && bus_wdata != 8'hAC && !wd_off) |=> rst_req);

    p_bit_key_r6: assert property (@(posedge clk) disable iff (rst)
        (key_wr && bus_bitop && !wd_off) |=> rst_req);

    p_bad_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !locked_q && bus_wdata[7:5] != 3'b011) |=> (rst_req && $stable(mode_q)));

    p_locked_r9: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> (locked_q && $stable(mode_q)));

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (wd_off && !key_wr) |=> ($stable(cnt_q) && !rst_req));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (clk_may_stop && (halt_i || stop_i) && !bus_wr) |=> $stable(cnt_q));

endmodule

bind wdt_keyguard wdt_keyguard_chk #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_bitop(bus_bitop), .halt_i(halt_i),
    .stop_i(stop_i), .clk_may_stop(clk_may_stop), .rst_req(rst_req),
    .cnt_q(cnt_q), .mode_q(mode_q), .locked_q(locked_q), .wd_off(wd_off)
);

// File: tb/sim_wdt_keyguard.sv
module sim_wdt_keyguard;

    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_bitop = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       halt_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       clk_may_stop = 1'b1;
    logic       rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    int n_pulse = 0;
    string tag = "R1";
    bit done = 1'b0;

    // reference model state
    bit       m_locked;
    bit [7:0] m_mode;
    int       m_cnt;
    bit       m_rst;
    bit       m_quiet, m_run, m_clr, m_bad, m_ov;
    int       m_lim;

    always #4 clk = ~clk;

    wdt_keyguard u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_bitop(bus_bitop), .rd_addr(rd_addr),
        .rd_data(rd_data), .halt_i(halt_i), .stop_i(stop_i),
        .clk_may_stop(clk_may_stop), .rst_req(rst_req)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_locked = 0; m_mode = 8'h67; m_cnt = 0; m_rst = 0;
        end else begin
            m_quiet = m_locked && m_mode[4];
            m_run   = !m_quiet && !(clk_may_stop && (halt_i || stop_i));
            m_lim   = (1 << (BASE + int'(m_mode[2:0]))) - 1;
            m_clr   = 0;
            m_bad   = 0;
            if (bus_wr && bus_addr == 2'd0) begin
                if (bus_bitop || m_locked || bus_wdata[7:5] != 3'b011)
                    m_bad = !m_quiet;
                else begin
                    m_locked = 1; m_mode = bus_wdata; m_clr = 1;
                end
            end else if (bus_wr && bus_addr == 2'd1) begin
                if (bus_bitop || bus_wdata != 8'hAC) m_bad = !m_quiet;
                else m_clr = 1;
            end
            m_ov = m_run && !m_clr && (m_cnt == m_lim);
            if (m_clr || m_ov) m_cnt = 0;
            else if (m_run) m_cnt = m_cnt + 1;
            m_rst = m_bad || m_ov;
        end
    end

    function automatic bit [7:0] exp_rd(input bit [1:0] a);
        if (a == 2'd0) return m_mode;
        if (a == 2'd1) return 8'h9A;
        return 8'h00;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check({tag, " rst_req"}, int'(rst_req), int'(m_rst));
            check({tag, " rd_data"}, int'(rd_data), int'(exp_rd(rd_addr)));
            if (rst_req) n_pulse++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d, input bit b);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_bitop = b;
        @(posedge clk); #1;
        bus_wr = 0; bus_bitop = 0;
    endtask

    // number of pulses seen over n cycles
    task automatic pulses_over(input int n, output int cnt);
        int start;
        start = n_pulse;
        step(n);
        @(negedge clk);
        cnt = n_pulse - start;
        #1;
    endtask

    initial begin
        int p;
        step(3);
        rst = 0;
        @(negedge clk);
        tag = "R1";
        check("R1 reset mode read", int'(rd_data), 8'h67);
        check("R1 reset rst_req", int'(rst_req), 0);
        #1 rd_addr = 2'd1;
        @(negedge clk);
        check("R4 key read", int'(rd_data), 8'h9A);
        #1 rd_addr = 2'd2;
        @(negedge clk);
        check("R4 unused read", int'(rd_data), 0);
        #1 rd_addr = 2'd0;

        tag = "R2";
        pulses_over(2100, p);
        check("R2 default period overflow count", p, 1);

        tag = "R3";
        for (int i = 0; i < 4; i++) begin
            step(1500);
            wr(2'd1, 8'hAC, 0);
        end
        pulses_over(10, p);
        check("R3 regular clears give no request", p, 0);

        tag = "R5";
        pulses_over(0, p);
        wr(2'd1, 8'h55, 0);
        pulses_over(2, p);
        check("R5 wrong key request", p, 1);

        tag = "R6";
        wr(2'd1, 8'hAC, 1);
        pulses_over(2, p);
        check("R6 bit key request", p, 1);

        tag = "R8";
        wr(2'd0, 8'h47, 0);
        pulses_over(2, p);
        check("R8 bad fixed bits request", p, 1);
        check("R8 not stored", int'(rd_data), 8'h67);

        tag = "R9";
        wr(2'd0, 8'h62, 1);
        pulses_over(2, p);
        check("R9 bit mode write request", p, 1);

        tag = "R7";
        wr(2'd0, 8'h6A, 0);
        @(negedge clk);
        check("R7 mode stored", int'(rd_data), 8'h6A);
        #1;
        pulses_over(200, p);
        check("R7 period 64 overflows in 200", p, 3);

        tag = "R9";
        wr(2'd1, 8'hAC, 0);
        wr(2'd0, 8'h70, 0);
        pulses_over(2, p);
        check("R9 second mode write request", p, 1);
        check("R9 mode unchanged", int'(rd_data), 8'h6A);

        tag = "R11";
        clk_may_stop = 1;
        wr(2'd1, 8'hAC, 0);
        step(40);
        halt_i = 1; step(100); halt_i = 0;
        stop_i = 1; step(100); stop_i = 0;
        step(10);
        pulses_over(20, p);
        check("R11 held count overflows after resume", p, 1);

        tag = "R12";
        clk_may_stop = 0;
        wr(2'd1, 8'hAC, 0);
        stop_i = 1;
        pulses_over(140, p);
        check("R12 stop does not pause", p, 2);
        stop_i = 0; halt_i = 1;
        pulses_over(70, p);
        check("R12 halt does not pause", p, 1);
        halt_i = 0;

        tag = "R10";
        rst = 1; step(2); rst = 0;
        wr(2'd0, 8'h78, 0);
        pulses_over(3000, p);
        check("R10 stopped no overflow", p, 0);
        wr(2'd0, 8'h61, 0);
        wr(2'd1, 8'h11, 0);
        wr(2'd1, 8'hAC, 1);
        wr(2'd0, 8'h61, 1);
        pulses_over(5, p);
        check("R10 stopped ignores illegal access", p, 0);
        check("R10 mode unchanged", int'(rd_data), 8'h78);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule